// File: doc/BRIEF.md
# Audio Stream Gateway Channel

This block is a single channel of an audio stream gateway. It keeps track of a circular buffer in local memory. Firmware sets up the channel through a small register file and then starts it. The registers hold an aligned base address, a buffer size, a segment size and a burst size. Two byte offsets, a write pointer and a read pointer, move around the buffer. The channel derives its buffer-full and not-empty status from these two pointers. It also raises a segment-complete flag each time a programmed number of bytes has been drained.

The write pointer can be advanced in two ways. In firmware-buffer mode, firmware writes a byte count to an increment register. In the other mode, a fill strobe from the producer side advances it by one burst. A drain strobe from the consumer side advances the read pointer by one burst, but only when a full burst is stored. Each strobe stands in for one memory transfer. The channel presents the addresses for these transfers as base plus pointer.

A container-size control bit selects narrow samples. Its value is passed to the packing logic. Two link-position registers accumulate the increments written to them. Starting the channel returns all position state to zero.

Top module: `gw_stream_channel`

## Requirements
- R1: After reset every register reads zero, `run` is low and `narrow_cont` is low.
- R2: The base register keeps only bits 23:7. The size register keeps only bits 23:4. The segment and burst registers keep bits 23:0. Register offsets: control 0x00, base 0x04, size 0x08, increment 0x0C, read pointer 0x10, write pointer 0x14, segment 0x18, burst 0x1C, link position 0x24, link buffer position 0x28.
- R3: A control write with bit 26 set starts the channel, but only if it is stopped and size, segment and burst are all nonzero. A control write with bit 26 clear stops it. While running, control bits 26 and 5 read 1.
- R4: Writes to the base, size, segment and burst registers are ignored while the channel runs. Writes to the two pointer registers (0x10, 0x14) are always ignored.
- R5: With control bit 23 set, a write of N to 0x0C advances the write pointer by N if N is no more than the free space; otherwise the write is ignored, and the fill strobe has no effect. With bit 23 clear, the fill strobe advances the write pointer by one burst when that much space is free, and writes to 0x0C are ignored.
- R6: A drain strobe advances the read pointer by one burst when at least one burst is stored; otherwise it is ignored. `drain_addr` equals base plus read pointer.
- R7: Each pointer wraps to zero when it reaches the buffer size.
- R8: Control bit 9 (full) is 1 when the stored bytes equal the buffer size. Control bit 8 (not empty) is 1 when any bytes are stored.
- R9: Control bit 11 is set when the bytes drained since it was last cleared reach the segment size; any excess is carried forward. Writing 1 to bit 11 clears it. If a set and a clear fall in the same cycle, the flag stays set.
- R10: Starting the channel resets both pointers, the segment count and flag, and both link registers to zero.
- R11: Control bit 31 is stored and driven on `narrow_cont` (1 means 16-bit or narrower samples, 0 means 32-bit containers).
- R12: Each write to 0x24 or to 0x28 adds the written value to that register. A read returns the running sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| fill_stb | input | 1 | Producer transferred one burst (used when bit 23 is clear) |
| drain_stb | input | 1 | Consumer transferred one burst |
| run | output | 1 | Channel is running |
| narrow_cont | output | 1 | Narrow sample container selected |
| drain_addr | output | 24 | Base plus read pointer |
| fill_addr | output | 24 | Base plus write pointer |

## Verification
Two functions can land on the same edge, and the bench covers both cases. In the first, a drain strobe that completes a segment meets a firmware write of 1 to bit 11. This is provoked by driving both in the same cycle; the test passes only if the flag reads set afterward and the read pointer has still moved. In the second, an increment write and a drain strobe are issued together across a wrap of the write pointer. The test judges both pointer offsets and the full and not-empty bits against the stored-byte count worked out by hand.

// File: rtl/gw_pkg.sv
package gw_pkg;
    localparam int unsigned REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_BASE  = 6'h04;
    localparam logic [REG_AW-1:0] OFS_SIZE  = 6'h08;
    localparam logic [REG_AW-1:0] OFS_FWINC = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_RDPTR = 6'h10;
    localparam logic [REG_AW-1:0] OFS_WRPTR = 6'h14;
    localparam logic [REG_AW-1:0] OFS_SEG   = 6'h18;
    localparam logic [REG_AW-1:0] OFS_BURST = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_LINK  = 6'h24;
    localparam logic [REG_AW-1:0] OFS_LPIB  = 6'h28;

    localparam int unsigned B_NARROW = 31;
    localparam int unsigned B_EN     = 26;
    localparam int unsigned B_FWBUF  = 23;
    localparam int unsigned B_SEG    = 11;
    localparam int unsigned B_FULL   = 9;
    localparam int unsigned B_NE     = 8;
    localparam int unsigned B_FIFO   = 5;
endpackage

// File: rtl/gw_ring_ptr.sv
module gw_ring_ptr #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] amount,
    input  logic [W-1:0] size,
    output logic [W-1:0] off,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] off;
        logic         wrap;
    } ptr_t;

    ptr_t    ptr_d, ptr_q;
    logic [W:0] sum;

    always_comb begin
        ptr_d = ptr_q;
        sum   = {1'b0, ptr_q.off} + {1'b0, amount};
        if (clr) begin
            ptr_d = '0;
        end else if (adv) begin
            if (sum >= {1'b0, size}) begin
                ptr_d.off  = W'(sum - {1'b0, size});
                ptr_d.wrap = ~ptr_q.wrap;
            end else begin
                ptr_d.off  = sum[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign off  = ptr_q.off;
    assign wrap = ptr_q.wrap;
endmodule

// File: rtl/gw_occupancy.sv
module gw_occupancy #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] wr_off,
    input  logic         wr_wrap,
    input  logic [W-1:0] rd_off,
    input  logic         rd_wrap,
    input  logic [W-1:0] size,
    output logic [W-1:0] level,
    output logic [W-1:0] free,
    output logic         full,
    output logic         nonempty
);
    always_comb begin
        if (wr_wrap == rd_wrap) level = wr_off - rd_off;
        else                    level = size - rd_off + wr_off;
        free     = size - level;
        full     = (wr_wrap != rd_wrap) && (wr_off == rd_off);
        nonempty = (wr_wrap != rd_wrap) || (wr_off != rd_off);
    end
endmodule

// File: rtl/gw_seg_tracker.sv
module gw_seg_tracker #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         adv,
    input  logic [W-1:0] amount,
    input  logic [W-1:0] seg_size,
    input  logic         w1c,
    output logic         flag
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         flag;
    } seg_t;

    seg_t       seg_d, seg_q;
    logic [W:0] sum;

    always_comb begin
        seg_d = seg_q;
        sum   = {1'b0, seg_q.cnt} + {1'b0, amount};
        if (clr_all) begin
            seg_d = '0;
        end else begin
            if (w1c) seg_d.flag = 1'b0;
            if (adv) begin
                if (sum >= {1'b0, seg_size}) begin
                    seg_d.cnt  = W'(sum - {1'b0, seg_size});
                    seg_d.flag = 1'b1;
                end else begin
                    seg_d.cnt  = sum[W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= seg_d;
    end

    assign flag = seg_q.flag;
endmodule

// File: rtl/gw_stream_channel.sv
module gw_stream_channel
    import gw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned BASE_LSB = 7,
    parameter int unsigned SIZE_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fill_stb,
    input  logic              drain_stb,
    output logic              run,
    output logic              narrow_cont,
    output logic [ADDR_W-1:0] drain_addr,
    output logic [ADDR_W-1:0] fill_addr
);
    localparam int unsigned PAD_W = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] BASE_MASK = {{(ADDR_W-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};
    localparam logic [ADDR_W-1:0] SIZE_MASK = {{(ADDR_W-SIZE_LSB){1'b1}}, {SIZE_LSB{1'b0}}};

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] size;
        logic [ADDR_W-1:0] seg;
        logic [ADDR_W-1:0] burst;
        logic              run;
        logic              fwbuf;
        logic              narrow;
        logic [DATA_W-1:0] link_pos;
        logic [DATA_W-1:0] lpib_pos;
    } regs_t;

    regs_t q, d;

    logic              start;
    logic              wr_ctrl;
    logic              cfg_ok;
    logic              wr_adv, rd_adv;
    logic [ADDR_W-1:0] wr_amount;
    logic [ADDR_W-1:0] wr_off, rd_off;
    logic              wr_wrap, rd_wrap;
    logic [ADDR_W-1:0] level, free;
    logic              full, nonempty;
    logic              seg_flag;
    logic [ADDR_W-1:0] size_q;

    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign cfg_ok  = (q.size != '0) && (q.seg != '0) && (q.burst != '0);
    assign size_q  = q.size;

    // register file next state
    always_comb begin
        d     = q;
        start = 1'b0;
        if (wr_ctrl) begin
            d.narrow = reg_wdata[B_NARROW];
            d.fwbuf  = reg_wdata[B_FWBUF];
            if (!reg_wdata[B_EN]) begin
                d.run = 1'b0;
            end else if (!q.run && cfg_ok) begin
                d.run = 1'b1;
                start = 1'b1;
            end
        end
        if (reg_wr && !q.run) begin
            case (reg_addr)
                OFS_BASE:  d.base  = reg_wdata[ADDR_W-1:0] & BASE_MASK;
                OFS_SIZE:  d.size  = reg_wdata[ADDR_W-1:0] & SIZE_MASK;
                OFS_SEG:   d.seg   = reg_wdata[ADDR_W-1:0];
                OFS_BURST: d.burst = reg_wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
        if (start) begin
            d.link_pos = '0;
            d.lpib_pos = '0;
        end else if (reg_wr && reg_addr == OFS_LINK) begin
            d.link_pos = q.link_pos + reg_wdata;
        end else if (reg_wr && reg_addr == OFS_LPIB) begin
            d.lpib_pos = q.lpib_pos + reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // pointer advance decisions
    always_comb begin
        wr_adv    = 1'b0;
        wr_amount = q.burst;
        if (q.run) begin
            if (q.fwbuf) begin
                wr_amount = reg_wdata[ADDR_W-1:0];
                wr_adv    = reg_wr && (reg_addr == OFS_FWINC) &&
                            (reg_wdata <= {{PAD_W{1'b0}}, free});
            end else begin
                wr_adv    = fill_stb && (q.burst <= free);
            end
        end
        rd_adv = q.run && drain_stb && (level >= q.burst);
    end

    gw_ring_ptr #(.W(ADDR_W)) u_wr_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .adv    (wr_adv),
        .amount (wr_amount),
        .size   (q.size),
        .off    (wr_off),
        .wrap   (wr_wrap)
    );

    gw_ring_ptr #(.W(ADDR_W)) u_rd_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .adv    (rd_adv),
        .amount (q.burst),
        .size   (q.size),
        .off    (rd_off),
        .wrap   (rd_wrap)
    );

    gw_occupancy #(.W(ADDR_W)) u_occ (
        .wr_off   (wr_off),
        .wr_wrap  (wr_wrap),
        .rd_off   (rd_off),
        .rd_wrap  (rd_wrap),
        .size     (q.size),
        .level    (level),
        .free     (free),
        .full     (full),
        .nonempty (nonempty)
    );

    gw_seg_tracker #(.W(ADDR_W)) u_seg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (start),
        .adv      (rd_adv),
        .amount   (q.burst),
        .seg_size (q.seg),
        .w1c      (wr_ctrl && reg_wdata[B_SEG]),
        .flag     (seg_flag)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[B_NARROW] = q.narrow;
                reg_rdata[B_EN]     = q.run;
                reg_rdata[B_FWBUF]  = q.fwbuf;
                reg_rdata[B_SEG]    = seg_flag;
                reg_rdata[B_FULL]   = full;
                reg_rdata[B_NE]     = nonempty;
                reg_rdata[B_FIFO]   = q.run;
            end
            OFS_BASE:  reg_rdata = {{PAD_W{1'b0}}, q.base};
            OFS_SIZE:  reg_rdata = {{PAD_W{1'b0}}, q.size};
            OFS_RDPTR: reg_rdata = {{PAD_W{1'b0}}, rd_off};
            OFS_WRPTR: reg_rdata = {{PAD_W{1'b0}}, wr_off};
            OFS_SEG:   reg_rdata = {{PAD_W{1'b0}}, q.seg};
            OFS_BURST: reg_rdata = {{PAD_W{1'b0}}, q.burst};
            OFS_LINK:  reg_rdata = q.link_pos;
            OFS_LPIB:  reg_rdata = q.lpib_pos;
            default:   reg_rdata = '0;
        endcase
    end

    assign run         = q.run;
    assign narrow_cont = q.narrow;
    assign drain_addr  = q.base + rd_off;
    assign fill_addr   = q.base + wr_off;
endmodule

// File: rtl/gw_stream_channel_chk.sv
module gw_stream_channel_chk #(
    parameter int unsigned ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              reg_wr,
    input logic [5:0]        reg_addr,
    input logic              drain_stb,
    input logic              cfg_ok,
    input logic [ADDR_W-1:0] wr_off,
    input logic [ADDR_W-1:0] rd_off,
    input logic [ADDR_W-1:0] size_q,
    input logic              full,
    input logic              nonempty,
    input logic              seg_flag
);
    a_r3_start_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(cfg_ok));

    a_r10_start_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (wr_off == '0 && rd_off == '0 && !seg_flag));

    a_r7_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (wr_off < size_q && rd_off < size_q));

    a_r8_full_implies_ne: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> nonempty);

    a_r6_rdptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_stb && !(reg_wr && reg_addr == 6'h00)) |=> $stable(rd_off));

    a_r9_seg_rise_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seg_flag) |-> $past(drain_stb));

    a_r4_size_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(size_q));
endmodule

bind gw_stream_channel gw_stream_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .drain_stb (drain_stb),
    .cfg_ok    (cfg_ok),
    .wr_off    (wr_off),
    .rd_off    (rd_off),
    .size_q    (size_q),
    .full      (full),
    .nonempty  (nonempty),
    .seg_flag  (seg_flag)
);

// File: tb/tb_gw_stream_channel.sv
module tb_gw_stream_channel;
    localparam logic [31:0] EN   = 32'h1 << 26;
    localparam logic [31:0] FIFO = 32'h1 << 5;
    localparam logic [31:0] FW   = 32'h1 << 23;
    localparam logic [31:0] SEG  = 32'h1 << 11;
    localparam logic [31:0] NAR  = 32'h1 << 31;
    localparam logic [31:0] FULL = 32'h1 << 9;
    localparam logic [31:0] NE   = 32'h1 << 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fill_stb = 1'b0;
    logic        drain_stb = 1'b0;
    logic        run;
    logic        narrow_cont;
    logic [23:0] drain_addr;
    logic [23:0] fill_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gw_stream_channel dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fill_stb    (fill_stb),
        .drain_stb   (drain_stb),
        .run         (run),
        .narrow_cont (narrow_cont),
        .drain_addr  (drain_addr),
        .fill_addr   (fill_addr)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // one write cycle, optional strobes in the same cycle
    task automatic cyc(input bit wr, input logic [5:0] a, input logic [31:0] v,
                       input bit fill, input bit drain);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = v;
        fill_stb = fill; drain_stb = drain;
        @(negedge clk);
        reg_wr = 1'b0; fill_stb = 1'b0; drain_stb = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        cyc(1'b1, a, v, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h00, v); check("R1 ctrl", v, 32'h0);
        rd(6'h08, v); check("R1 size", v, 32'h0);
        rd(6'h14, v); check("R1 wrptr", v, 32'h0);
        check("R1 run", {31'b0, run}, 32'h0);
        check("R1 narrow", {31'b0, narrow_cont}, 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); check("R2 base mask", v, 32'h00FF_FF80);
        wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, v); check("R2 size mask", v, 32'h00FF_FFF0);
        wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, v); check("R2 seg mask", v, 32'h00FF_FFFF);
        wr(6'h04, 32'h1000); wr(6'h08, 32'h0); wr(6'h18, 32'h20); wr(6'h1C, 32'h10);
    endtask

    task automatic t_enable_guard();
        logic [31:0] v;
        wr(6'h00, EN | FIFO | FW);
        check("R3 no start without size", {31'b0, run}, 32'h0);
        wr(6'h08, 32'h40);
        wr(6'h00, EN | FIFO | FW);
        check("R3 start", {31'b0, run}, 32'h1);
        rd(6'h00, v); check("R3 ctrl bits", v & (EN | FIFO | FW), EN | FIFO | FW);
        wr(6'h08, 32'h80); rd(6'h08, v); check("R4 size frozen", v, 32'h40);
        wr(6'h10, 32'h5); rd(6'h10, v); check("R4 rdptr ro", v, 32'h0);
        wr(6'h14, 32'h7); rd(6'h14, v); check("R4 wrptr ro", v, 32'h0);
    endtask

    task automatic t_fw_mode();
        logic [31:0] v;
        wr(6'h0C, 32'h30); rd(6'h14, v); check("R5 fw incr", v, 32'h30);
        rd(6'h00, v); check("R8 ne no full", v & (FULL | NE), NE);
        cyc(1'b0, 6'h00, 32'h0, 1'b1, 1'b0);
        rd(6'h14, v); check("R5 fill ignored in fw mode", v, 32'h30);
        wr(6'h0C, 32'h20); rd(6'h14, v); check("R5 overrun ignored", v, 32'h30);
        wr(6'h0C, 32'h10); rd(6'h14, v); check("R7 wrptr wrap", v, 32'h0);
        rd(6'h00, v); check("R8 full", v & (FULL | NE), FULL | NE);
        check("R5 fill_addr", {8'b0, fill_addr}, 32'h1000);
    endtask

    task automatic t_drain();
        logic [31:0] v;
        check("R6 drain_addr start", {8'b0, drain_addr}, 32'h1000);
        cyc(1'b0, 6'h00, 32'h0, 1'b0, 1'b1);
        rd(6'h10, v); check("R6 rdptr", v, 32'h10);
        check("R6 drain_addr", {8'b0, drain_addr}, 32'h1010);
        rd(6'h00, v); check("R9 seg not yet", v & SEG, 32'h0);
        cyc(1'b0, 6'h00, 32'h0, 1'b0, 1'b1);
        rd(6'h00, v); check("R9 seg set", v & SEG, SEG);
        wr(6'h00, EN | FIFO | FW | SEG);
        rd(6'h00, v); check("R9 seg w1c", v & (SEG | EN), EN);
        rd(6'h10, v); check("R3 rewrite keeps pointers", v, 32'h20);
        cyc(1'b0, 6'h00, 32'h0, 1'b0, 1'b1);
        cyc(1'b0, 6'h00, 32'h0, 1'b0, 1'b1);
        rd(6'h10, v); check("R7 rdptr wrap", v, 32'h0);
        rd(6'h00, v); check("R8 empty", v & (FULL | NE | SEG), SEG);
        cyc(1'b0, 6'h00, 32'h0, 1'b0, 1'b1);
        rd(6'h10, v); check("R6 drain on empty ignored", v, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        wr(6'h00, EN | FIFO | FW | SEG);
        wr(6'h0C, 32'h30);
        cyc(1'b0, 6'h00, 32'h0, 1'b0, 1'b1);
        cyc(1'b1, 6'h00, EN | FIFO | FW | SEG, 1'b0, 1'b1);
        rd(6'h00, v); check("R9 set wins over clear", v & SEG, SEG);
        rd(6'h10, v); check("R6 rdptr during w1c", v, 32'h20);
        cyc(1'b1, 6'h0C, 32'h10, 1'b0, 1'b1);
        rd(6'h14, v); check("R5 wrptr with drain", v, 32'h0);
        rd(6'h10, v); check("R6 rdptr with incr", v, 32'h30);
        rd(6'h00, v); check("R8 level after both", v & (FULL | NE), NE);
    endtask

    task automatic t_link();
        logic [31:0] v;
        wr(6'h24, 32'd5); wr(6'h24, 32'd7);
        rd(6'h24, v); check("R12 link sum", v, 32'd12);
        wr(6'h28, 32'd3);
        rd(6'h28, v); check("R12 lpib sum", v, 32'd3);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(6'h00, 32'h0);
        rd(6'h00, v); check("R3 stop", v & (EN | FIFO), 32'h0);
        wr(6'h00, NAR);
        check("R11 narrow out", {31'b0, narrow_cont}, 32'h1);
        rd(6'h00, v); check("R11 narrow bit", v & NAR, NAR);
        wr(6'h00, NAR | EN | FIFO);
        rd(6'h10, v); check("R10 rdptr cleared", v, 32'h0);
        rd(6'h00, v); check("R10 seg cleared", v & (SEG | NE), 32'h0);
        rd(6'h24, v); check("R10 link cleared", v, 32'h0);
        cyc(1'b0, 6'h00, 32'h0, 1'b1, 1'b0);
        rd(6'h14, v); check("R5 fill strobe", v, 32'h10);
        wr(6'h0C, 32'h10);
        rd(6'h14, v); check("R5 incr ignored in strobe mode", v, 32'h10);
        cyc(1'b0, 6'h00, 32'h0, 1'b0, 1'b1);
        rd(6'h10, v); check("R6 drain after fill", v, 32'h10);
        cyc(1'b0, 6'h00, 32'h0, 1'b0, 1'b1);
        rd(6'h10, v); check("R6 short drain ignored", v, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_enable_guard();
        t_fw_mode();
        t_drain();
        t_same_cycle();
        t_link();
        t_restart();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule